// File: doc/BRIEF.md
# Eight-Channel Extended Match Timer Bank

This block holds eight extended timer channels, numbered 4 to 11. Each channel has a counter, a match value and a control word. The control word selects one of five rate ticks that the surrounding chip supplies. It also decides whether the channel compares its match value against its own counter or against a counter shared by its group. Further control bits set reset-on-match, periodic or one-shot matching, and a snapshot mode. In that mode, reading a counter captures the neighbouring counter into a snapshot register.

A match raises a status bit, but only when the channel's enable bit is set. The status and enable bits sit at positions 4 to 11, so they merge with those of a base timer. All status bits drive one shared interrupt line. Software reaches the block through a simple register bus. A write lands in one clock. A read returns its data on the clock after the read strobe.

Top module: `ext_timer_bank`

## Requirements
- R1: After reset, every counter, match value, control word, status bit, enable bit and the snapshot read back as zero, and `irq_o` is low.
- R2: Control bits [2:0] choose the rate. Code k from 1 to 5 advances the counter by one on each cycle where `tick_i[k-1]` is high. Codes 0, 6 and 7 hold the counter.
- R3: With control bit 7 set, a channel compares against its own counter. With it clear, channels 4–7 compare against channel 4's counter, channels 8–9 against channel 8's, and channels 10–11 against channel 10's.
- R4: On a channel that does not own its group counter, a clear control bit 7 freezes that channel's own counter.
- R5: A match occurs when the compared counter steps onto the match value. Status bit 4+n (n = channel − 4) is set only if enable bit 4+n is set.
- R6: With control bit 6 set, matches repeat. With it clear, only the first match counts until the match value or the control word is written again.
- R7: With control bit 3 set, the channel's own counter loads zero on a match instead of the match value.
- R8: On channels 9 and 11 with control bit 9 set, a read of that channel's counter copies the counter of channel 8 or 10 into the snapshot register at 0x20.
- R9: Control words of channels 4–7 keep bits [7:0] only. Those of channels 8–11 keep bits [9:0], and on those channels bit 8 stops the channel's own counter.
- R10: `irq_o` is high while any status bit is set. Writing ones to the status register at 0x14 clears those bits, and the line drops only when all of them are clear.
- R11: Register map: counter of channel c at 0x40+4·(c−4), match at 0x80+4·(c−4), control at 0xC0+4·(c−4), enable at 0x1C (bits 11:4), status at 0x14. A counter write loads the value directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | NSRC (5) | One-cycle rate ticks: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data, valid the cycle after `rd_en_i` |
| irq_o | output | 1 | Combined match interrupt |

## Verification
The bench uses the default widths: 32-bit counters and a 32-bit bus. Counts stay in the single digits, so the sweep never reaches wrap-around. It sweeps all eight rate codes on every channel, both with its own counter and with bit 8 set. This covers every tick-to-counter route and the clock-off gate on the upper four channels. Targeted sequences then exercise the three counter-sharing groups, one-shot and periodic matching with and without reset-to-zero, enable gating, both snapshot pairs, and release of the shared line.

// File: rtl/ext_tmr_pkg.sv
// Package ext_tmr_pkg
// Shared constants for the extended timer bank: register pages, fixed
// addresses, control-bit positions and the channel grouping rules.
// Assumes eight channels; channel index n here means timer channel n+4.
package ext_tmr_pkg;

    localparam int NCH   = 8;   // channels in the bank
    localparam int NSRC  = 5;   // rate tick inputs
    localparam int AW    = 8;   // byte address width
    localparam int CTL_W = 10;  // widest control word

    localparam logic [AW-1:0] ADDR_STAT = 8'h14;
    localparam logic [AW-1:0] ADDR_IEN  = 8'h1C;
    localparam logic [AW-1:0] ADDR_SNAP = 8'h20;

    // addr[7:5] selects a page of eight word registers
    localparam logic [2:0] PAGE_CNT = 3'b010;  // 0x40..0x5C
    localparam logic [2:0] PAGE_MAT = 3'b100;  // 0x80..0x9C
    localparam logic [2:0] PAGE_CTL = 3'b110;  // 0xC0..0xDC

    localparam int B_RST  = 3;  // zero own counter on match
    localparam int B_PER  = 6;  // periodic match
    localparam int B_OWN  = 7;  // compare against own counter
    localparam int B_OFF  = 8;  // clock off (upper four channels)
    localparam int B_SNAP = 9;  // snapshot on counter read

    // index of the channel whose counter the group shares
    function automatic int group_owner(input int n);
        return (n < 4) ? 0 : ((n < 6) ? 4 : 6);
    endfunction

    // number of control bits a channel keeps
    function automatic int ctl_bits(input int n);
        return (n < 4) ? 8 : 10;
    endfunction

    // channels whose counter read may latch the preceding counter
    function automatic bit snap_capable(input int n);
        return (n == 5) || (n == 7);
    endfunction

endpackage

// File: rtl/ext_tmr_chan.sv
// Module ext_tmr_chan
// One timer channel: counter, match value, control word and the one-shot
// arming flag. Produces a match pulse when the compared counter steps onto
// the match value. Assumes CW does not exceed the bus width and that the
// group owner's counter and step are supplied on shr_cnt_i / shr_step_i.
module ext_tmr_chan
    import ext_tmr_pkg::*;
#(
    parameter int IDX = 0,
    parameter int CW  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  tick_i,
    input  logic             wr_cnt_i,
    input  logic             wr_mat_i,
    input  logic             wr_ctl_i,
    input  logic [CW-1:0]    wval_i,
    input  logic [CTL_W-1:0] wctl_i,
    input  logic [CW-1:0]    shr_cnt_i,
    input  logic             shr_step_i,
    output logic [CW-1:0]    cnt_o,
    output logic             step_o,
    output logic [CW-1:0]    mat_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             hit_o
);

    localparam int               KEEP     = ctl_bits(IDX);
    localparam logic [CTL_W-1:0] CTL_MASK = CTL_W'((1 << KEEP) - 1);
    localparam bit               IS_OWNER = (group_owner(IDX) == IDX);
    localparam bit               HAS_OFF  = (KEEP > B_OFF);

    logic [CW-1:0]    cnt_q, mat_q, cmp_cnt;
    logic [CTL_W-1:0] ctl_q;
    logic             armed_q, src_tick, clk_off, own_run, cmp_step;

    // pick the tick line named by the rate code
    always_comb begin
        src_tick = 1'b0;
        for (int k = 0; k < NSRC; k++) begin
            if (ctl_q[2:0] == 3'(k + 1)) src_tick = tick_i[k];
        end
    end

    // decide whether the own counter runs and what the match compares against
    always_comb begin
        clk_off  = HAS_OFF && ctl_q[B_OFF];
        own_run  = (ctl_q[B_OWN] || IS_OWNER) && !clk_off;
        step_o   = own_run && src_tick;
        cmp_cnt  = ctl_q[B_OWN] ? cnt_q  : shr_cnt_i;
        cmp_step = ctl_q[B_OWN] ? step_o : shr_step_i;
        hit_o    = armed_q && cmp_step && ((cmp_cnt + CW'(1)) == mat_q);
    end

    // counter: direct load, zero on match, or advance on its tick
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (wr_cnt_i)            cnt_q <= wval_i;
        else if (hit_o && ctl_q[B_RST]) cnt_q <= '0;
        else if (step_o)              cnt_q <= cnt_q + CW'(1);
    end

    // match value and control word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mat_q <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_mat_i) mat_q <= wval_i;
            if (wr_ctl_i) ctl_q <= wctl_i & CTL_MASK;
        end
    end

    // one-shot arming: rearmed by a rewrite, consumed by a non-periodic match
    always_ff @(posedge clk) begin
        if (!rst_n)                        armed_q <= 1'b1;
        else if (wr_mat_i || wr_ctl_i)     armed_q <= 1'b1;
        else if (hit_o && !ctl_q[B_PER])   armed_q <= 1'b0;
    end

    assign cnt_o = cnt_q;
    assign mat_o = mat_q;
    assign ctl_o = ctl_q;

endmodule

// File: rtl/ext_tmr_regs.sv
// Module ext_tmr_regs
// Register-bus side of the bank: address decode into per-channel write
// strobes, status and enable bits, snapshot capture and the registered
// read mux. Assumes word-aligned accesses; other offsets read zero.
module ext_tmr_regs
    import ext_tmr_pkg::*;
#(
    parameter int CW = 32,
    parameter int DW = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic                       rd_en_i,
    input  logic [AW-1:0]              addr_i,
    input  logic [NCH-1:0]             wbits_i,
    input  logic [NCH-1:0][CW-1:0]     cnt_i,
    input  logic [NCH-1:0][CW-1:0]     mat_i,
    input  logic [NCH-1:0][CTL_W-1:0]  ctl_i,
    input  logic [NCH-1:0]             hit_i,
    output logic [NCH-1:0]             wr_cnt_o,
    output logic [NCH-1:0]             wr_mat_o,
    output logic [NCH-1:0]             wr_ctl_o,
    output logic [NCH-1:0]             stat_o,
    output logic [NCH-1:0]             ien_o,
    output logic [DW-1:0]              rdata_o
);

    logic [2:0]           page, sel;
    logic                 aligned, wr_stat, wr_ien, rd_cnt;
    logic [NCH-1:0]       stat_q, ien_q, snap_req;
    logic [NCH-1:0][CW-1:0] snap_val;
    logic [CW-1:0]        snap_q;
    logic [DW-1:0]        rdata_q;

    // split the address into page, channel select and alignment
    always_comb begin
        page    = addr_i[7:5];
        sel     = addr_i[4:2];
        aligned = (addr_i[1:0] == 2'b00);
        wr_stat = wr_en_i && (addr_i == ADDR_STAT);
        wr_ien  = wr_en_i && (addr_i == ADDR_IEN);
        rd_cnt  = rd_en_i && aligned && (page == PAGE_CNT);
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_dec
            // per-channel write strobes
            assign wr_cnt_o[g] = wr_en_i && aligned && (page == PAGE_CNT) && (sel == 3'(g));
            assign wr_mat_o[g] = wr_en_i && aligned && (page == PAGE_MAT) && (sel == 3'(g));
            assign wr_ctl_o[g] = wr_en_i && aligned && (page == PAGE_CTL) && (sel == 3'(g));
            if (snap_capable(g)) begin : g_snap
                assign snap_req[g] = rd_cnt && (sel == 3'(g)) && ctl_i[g][B_SNAP];
                assign snap_val[g] = cnt_i[g-1];
            end else begin : g_nosnap
                assign snap_req[g] = 1'b0;
                assign snap_val[g] = '0;
            end
        end
    endgenerate

    // status bits: enabled matches set, write-one clears
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (wr_stat ? (stat_q & ~wbits_i) : stat_q) | (hit_i & ien_q);
    end

    // enable bits
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (wr_ien) ien_q <= wbits_i;
    end

    // snapshot capture on a qualifying counter read
    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else begin
            for (int i = 0; i < NCH; i++) begin
                if (snap_req[i]) snap_q <= snap_val[i];
            end
        end
    end

    // registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd_en_i) begin
            rdata_q <= '0;
            if (addr_i == ADDR_STAT)      rdata_q <= DW'({stat_q, 4'b0000});
            else if (addr_i == ADDR_IEN)  rdata_q <= DW'({ien_q, 4'b0000});
            else if (addr_i == ADDR_SNAP) rdata_q <= DW'(snap_q);
            else if (aligned && page == PAGE_CNT) rdata_q <= DW'(cnt_i[sel]);
            else if (aligned && page == PAGE_MAT) rdata_q <= DW'(mat_i[sel]);
            else if (aligned && page == PAGE_CTL) rdata_q <= DW'(ctl_i[sel]);
        end
    end

    assign stat_o  = stat_q;
    assign ien_o   = ien_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/ext_timer_bank.sv
// Module ext_timer_bank
// Top of the eight-channel extended match timer bank. Instantiates the
// channels, wires each one to its group owner's counter, and merges the
// status bits into one interrupt line. Assumes CW <= DW and DW >= 12.
module ext_timer_bank
    import ext_tmr_pkg::*;
#(
    parameter int CW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] tick_i,
    input  logic            wr_en_i,
    input  logic            rd_en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    output logic            irq_o
);

    logic [NCH-1:0][CW-1:0]    cnt_vec, mat_vec;
    logic [NCH-1:0][CTL_W-1:0] ctl_vec;
    logic [NCH-1:0]            step_vec, hit_vec, wr_cnt_vec, wr_mat_vec, wr_ctl_vec;
    logic [NCH-1:0]            stat_vec, ien_vec;

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            ext_tmr_chan #(.IDX(g), .CW(CW)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick_i     (tick_i),
                .wr_cnt_i   (wr_cnt_vec[g]),
                .wr_mat_i   (wr_mat_vec[g]),
                .wr_ctl_i   (wr_ctl_vec[g]),
                .wval_i     (wdata_i[CW-1:0]),
                .wctl_i     (wdata_i[CTL_W-1:0]),
                .shr_cnt_i  (cnt_vec[group_owner(g)]),
                .shr_step_i (step_vec[group_owner(g)]),
                .cnt_o      (cnt_vec[g]),
                .step_o     (step_vec[g]),
                .mat_o      (mat_vec[g]),
                .ctl_o      (ctl_vec[g]),
                .hit_o      (hit_vec[g])
            );
        end
    endgenerate

    ext_tmr_regs #(.CW(CW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wbits_i  (wdata_i[11:4]),
        .cnt_i    (cnt_vec),
        .mat_i    (mat_vec),
        .ctl_i    (ctl_vec),
        .hit_i    (hit_vec),
        .wr_cnt_o (wr_cnt_vec),
        .wr_mat_o (wr_mat_vec),
        .wr_ctl_o (wr_ctl_vec),
        .stat_o   (stat_vec),
        .ien_o    (ien_vec),
        .rdata_o  (rdata_o)
    );

    // any pending enabled match holds the shared line
    assign irq_o = |stat_vec;

endmodule

// File: rtl/ext_timer_bank_chk.sv
// Module ext_timer_bank_chk
// Property checker bound to ext_timer_bank. Watches status, enables,
// counters and control words across cycles.
module ext_timer_bank_chk
    import ext_tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en_i,
    input logic [AW-1:0]             addr_i,
    input logic [NCH-1:0]            wbits,
    input logic [NCH-1:0]            stat,
    input logic [NCH-1:0]            ien,
    input logic [NCH-1:0]            hit,
    input logic [NCH-1:0]            wr_cnt,
    input logic [NCH-1:0][CW-1:0]    cnt,
    input logic [NCH-1:0][CTL_W-1:0] ctl
);

    // R5: a status bit can only rise where the enable was set
    a_r5_enable_gates_status: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(ien)) == '0));

    // R10: written ones clear their status bits unless a match lands at once
    a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_STAT) |=> ((stat & $past(wbits) & ~$past(hit)) == '0));

    // R2: channel 4 with a stopped rate code keeps its counter
    a_r2_stopped_rate_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl[0][2:0] == 3'd0 || ctl[0][2:1] == 2'b11) && !wr_cnt[0] && !(hit[0] && ctl[0][B_RST]))
        |=> $stable(cnt[0]));

    // R4: channel 5 borrowing the group counter freezes its own
    a_r4_borrower_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl[1][B_OWN] && !wr_cnt[1] && !(hit[1] && ctl[1][B_RST])) |=> $stable(cnt[1]));

    // R9: channel 8 with its clock switched off keeps its counter
    a_r9_clock_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[4][B_OFF] && !wr_cnt[4] && !(hit[4] && ctl[4][B_RST])) |=> $stable(cnt[4]));

endmodule

bind ext_timer_bank ext_timer_bank_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wbits   (wdata_i[11:4]),
    .stat    (stat_vec),
    .ien     (ien_vec),
    .hit     (hit_vec),
    .wr_cnt  (wr_cnt_vec),
    .cnt     (cnt_vec),
    .ctl     (ctl_vec)
);

// File: tb/ext_timer_bank_bench.sv
// Bench for ext_timer_bank: register-level sequences with expected values
// worked out from the requirements.
module ext_timer_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  tick = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          total = 0, fails = 0;
    logic [31:0] v;

    always #10 clk = ~clk;  // 50 MHz

    ext_timer_bank u_ext_timer_bank (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [7:0] a_cnt(input int n); return 8'(8'h40 + 4 * n); endfunction
    function automatic logic [7:0] a_mat(input int n); return 8'(8'h80 + 4 * n); endfunction
    function automatic logic [7:0] a_ctl(input int n); return 8'(8'hC0 + 4 * n); endfunction
    localparam logic [7:0] A_STAT = 8'h14, A_IEN = 8'h1C, A_SNAP = 8'h20;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic pulse(input logic [4:0] m);
        @(negedge clk); tick = m;
        @(negedge clk); tick = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();

        // R1: everything reads zero after reset
        chk("R1 irq", {31'b0, irq}, 32'h0);
        for (int n = 0; n < 8; n++) begin
            rd_chk("R1 cnt", a_cnt(n), 32'h0);
            rd_chk("R1 mat", a_mat(n), 32'h0);
            rd_chk("R1 ctl", a_ctl(n), 32'h0);
        end
        rd_chk("R1 stat", A_STAT, 32'h0);
        rd_chk("R1 ien", A_IEN, 32'h0);
        rd_chk("R1 snap", A_SNAP, 32'h0);

        // R11: match and counter write and read back; enable keeps bits 11:4
        for (int n = 0; n < 8; n++) begin
            wr(a_mat(n), 32'hA5000000 + n);
            rd_chk("R11 mat", a_mat(n), 32'hA5000000 + n);
            wr(a_mat(n), 32'h0);
            wr(a_cnt(n), 32'h100 * n + 7);
            rd_chk("R11 cnt", a_cnt(n), 32'h100 * n + 7);
        end
        wr(A_IEN, 32'hFFFFFFFF);
        rd_chk("R11 ien mask", A_IEN, 32'h00000FF0);
        wr(A_IEN, 32'h0);

        // R9: control width per channel
        for (int n = 0; n < 8; n++) begin
            wr(a_ctl(n), 32'hFFFFFFFF);
            rd_chk("R9 ctl width", a_ctl(n), (n < 4) ? 32'hFF : 32'h3FF);
        end

        // R2 and R9: sweep rate codes, own counter, with and without clock-off
        for (int n = 0; n < 8; n++) begin
            for (int off = 0; off < 2; off++) begin
                for (int code = 0; code < 8; code++) begin
                    int exp;
                    wr(a_ctl(n), 32'h80 | (off << 8) | code);
                    wr(a_cnt(n), 32'h0);
                    for (int j = 0; j < 5; j++) pulse(5'(1 << j));
                    exp = (code >= 1 && code <= 5) ? 1 : 0;
                    if (off == 1 && n >= 4) exp = 0;
                    rd_chk(off ? "R9 clock-off sweep" : "R2 rate sweep", a_cnt(n), 32'(exp));
                end
            end
        end
        // R2: all ticks together still one step
        wr(a_ctl(0), 32'h83);
        wr(a_cnt(0), 32'h0);
        pulse(5'h1F);
        rd_chk("R2 simultaneous ticks", a_cnt(0), 32'h1);

        // R3 and R4: three sharing groups
        do_reset();
        wr(A_IEN, 32'h00000A20);
        wr(a_ctl(0), 32'h01); wr(a_ctl(1), 32'h01); wr(a_mat(1), 32'h3);
        pulse(5'h01); pulse(5'h01);
        rd_chk("R3 group4 before", A_STAT, 32'h0);
        pulse(5'h01);
        rd_chk("R3 group4 match", A_STAT, 32'h20);
        chk("R10 irq set", {31'b0, irq}, 32'h1);
        rd_chk("R4 borrower frozen", a_cnt(1), 32'h0);
        rd_chk("R3 owner count", a_cnt(0), 32'h3);
        wr(a_ctl(4), 32'h04); wr(a_ctl(5), 32'h04); wr(a_mat(5), 32'h2);
        pulse(5'h08); pulse(5'h08);
        rd_chk("R3 group8 match", A_STAT, 32'h220);
        rd_chk("R4 ch9 frozen", a_cnt(5), 32'h0);
        wr(a_ctl(6), 32'h02); wr(a_ctl(7), 32'h02); wr(a_mat(7), 32'h1);
        pulse(5'h02);
        rd_chk("R3 group10 match", A_STAT, 32'hA20);

        // R5: match with enable off leaves status clear
        do_reset();
        wr(a_ctl(2), 32'h81); wr(a_mat(2), 32'h1);
        pulse(5'h01);
        rd_chk("R5 gated", A_STAT, 32'h0);
        chk("R5 gated irq", {31'b0, irq}, 32'h0);
        wr(A_IEN, 32'h40); wr(a_mat(2), 32'h1); wr(a_cnt(2), 32'h0);
        pulse(5'h01);
        rd_chk("R5 enabled", A_STAT, 32'h40);

        // R6 and R7 on channel 7
        do_reset();
        wr(A_IEN, 32'h80);
        wr(a_ctl(3), 32'hC9); wr(a_mat(3), 32'h2);
        pulse(5'h01); pulse(5'h01);
        rd_chk("R6 periodic first", A_STAT, 32'h80);
        rd_chk("R7 zero on match", a_cnt(3), 32'h0);
        wr(A_STAT, 32'h80);
        rd_chk("R10 cleared", A_STAT, 32'h0);
        chk("R10 irq low", {31'b0, irq}, 32'h0);
        pulse(5'h01); pulse(5'h01);
        rd_chk("R6 periodic again", A_STAT, 32'h80);
        wr(A_STAT, 32'h80);
        wr(a_ctl(3), 32'h89); wr(a_cnt(3), 32'h0);
        pulse(5'h01); pulse(5'h01);
        rd_chk("R6 one-shot first", A_STAT, 32'h80);
        wr(A_STAT, 32'h80);
        pulse(5'h01); pulse(5'h01);
        rd_chk("R6 one-shot silent", A_STAT, 32'h0);
        rd_chk("R6 one-shot count", a_cnt(3), 32'h2);
        wr(a_mat(3), 32'h2); wr(a_cnt(3), 32'h0);
        pulse(5'h01); pulse(5'h01);
        rd_chk("R6 rearmed", A_STAT, 32'h80);
        wr(A_STAT, 32'h80);
        wr(a_ctl(3), 32'hC1); wr(a_cnt(3), 32'h0);
        pulse(5'h01); pulse(5'h01);
        rd_chk("R7 no reset keeps value", a_cnt(3), 32'h2);

        // R10: line stays up until every bit is cleared
        do_reset();
        wr(A_IEN, 32'h30);
        wr(a_ctl(0), 32'h81); wr(a_mat(0), 32'h1);
        wr(a_ctl(1), 32'h81); wr(a_mat(1), 32'h1);
        pulse(5'h01);
        rd_chk("R10 two bits", A_STAT, 32'h30);
        wr(A_STAT, 32'h10);
        chk("R10 irq held", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h20);
        chk("R10 irq dropped", {31'b0, irq}, 32'h0);

        // R8: snapshot pairs
        do_reset();
        wr(a_ctl(4), 32'h84); wr(a_cnt(4), 32'd100);
        wr(a_ctl(5), 32'h280);
        for (int k = 0; k < 5; k++) pulse(5'h08);
        rd(a_cnt(5), v);
        rd_chk("R8 snap ch8", A_SNAP, 32'd105);
        wr(a_cnt(6), 32'd7); wr(a_ctl(7), 32'h80);
        rd(a_cnt(7), v);
        rd_chk("R8 no snap without bit9", A_SNAP, 32'd105);
        wr(a_ctl(7), 32'h280);
        rd(a_cnt(7), v);
        rd_chk("R8 snap ch10", A_SNAP, 32'd7);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule